// File: doc/BRIEF.md
# Latched Timestamp Register Interface

This block puts an 8-bit register bus in front of a free-running 16-bit timer and keeps a 24-bit count of that timer's overflows. The timer is outside the block. Its current value, its overflow pulse and its running state arrive as inputs. Software reads the timer and the overflow count one byte at a time. Each multi-byte value stays coherent because reading its lowest byte freezes the other bytes in latch registers. With the latch-mode bit set, reading the timer low byte also freezes the whole overflow count. Software then reads a single timestamp whose parts all come from the same clock cycle.

Writes to the timer are staged. The low byte is held inside the block, and writing the high byte sends the full 16-bit value to the timer as a one-cycle load pulse. If the timer is stopped, the pulse is a counter load. If the timer is running, the pulse is a delta load, which the timer uses to stretch its current period. Two 3-bit select fields in a control register choose which multiplexed source appears behind the timer bytes and behind the overflow bytes. Only source 000 lives in this block. Every other source reads as zero and ignores writes.

Top module: `tstamp_regif`

## Requirements
- R1: After reset, bus_rdata is 0x00, the control register reads 0x00, the overflow count is zero, and neither load pulse is asserted. bus_rdata changes only on a clock edge where bus_rd is high, and it keeps its value otherwise.
- R2: The overflow count rises by exactly one on every clock edge where tmr_ovf is high, with carries across byte boundaries, and it holds its value otherwise.
- R3: A read of address 1 (timer low) with timer select 000 returns tmr_value[7:0] and captures tmr_value[15:8]. A later read of address 2 (timer high) returns that captured byte, even if the timer has moved on since.
- R4: When control bit 0 (latch mode) is 1, a timer-low read also captures all 24 bits of the overflow count. Reads of addresses 3, 4 and 5 (overflow bytes 0, 1 and 2) then return the captured bytes, even after further overflow pulses.
- R5: When latch mode is 0, a read of address 3 returns the live low byte of the overflow count and captures bytes 1 and 2. Later reads of addresses 4 and 5 return those captured bytes.
- R6: A write to address 1 with timer select 000 only stages the byte. No load pulse follows it.
- R7: A write to address 2 with timer select 000 while tmr_running is 0 raises ld_count for exactly one cycle, starting on the edge after the write. ld_value carries {written byte, staged low byte}.
- R8: The same write while tmr_running is 1 raises ld_delta instead of ld_count, with the same value rule. The two pulses are never high together.
- R9: A high-byte write with no low-byte write since the last commit combines the new high byte with the last staged low byte.
- R10: The control register sits at address 0. Bit 0 is latch mode, bits 3:1 are the timer select and bits 6:4 are the overflow select. While a select is nonzero, its byte addresses read 0x00, timer-byte writes are ignored (no pulse, staged byte kept), and no capture takes place.
- R11: The control register reads back the written value with bit 7 forced to 0. Unmapped addresses 6 and 7 read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| tmr_value | input | 16 | Current timer count |
| tmr_ovf | input | 1 | Timer overflow pulse |
| tmr_running | input | 1 | Timer is in its running state |
| ld_count | output | 1 | One-cycle pulse: load the timer counter |
| ld_delta | output | 1 | One-cycle pulse: load the delta counter |
| ld_value | output | 16 | Value that goes with either load pulse |

## Verification
Every result is due one clock edge after its stimulus. Read data appears on the edge that samples bus_rd. A load pulse and its value appear on the edge that samples the high-byte write, and the pulse is gone one edge later. Each overflow pulse is counted on the edge that samples it. The bench drives each access on a falling edge and samples outputs on the next falling edge. Each result is therefore read half a cycle after the single register stage that produces it. For every capture test, the timer value or the overflow count is changed after the capturing read and before the dependent reads, so a byte read live cannot pass as a captured one.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
   localparam int unsigned ADR_W = 3;
   typedef logic [ADR_W-1:0] adr_t;

   // register addresses; overflow bytes occupy consecutive addresses from ADR_OB0
   localparam adr_t ADR_CTRL = 3'd0;
   localparam adr_t ADR_TLO  = 3'd1;
   localparam adr_t ADR_THI  = 3'd2;
   localparam adr_t ADR_OB0  = 3'd3;
endpackage

// File: rtl/tsr_ovf_counter.sv
module tsr_ovf_counter #(
   parameter int unsigned OVF_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [OVF_W-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   count <= '0;
      else if (inc) count <= count + 1'b1;
   end

   p_ovf_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      inc |=> count == $past(count) + 1'b1);
   p_ovf_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(count));
endmodule

// File: rtl/tsr_write_stage.sv
module tsr_write_stage #(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned TMR_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lo_we,
   input  logic              hi_we,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              running,
   output logic              ld_count,
   output logic              ld_delta,
   output logic [TMR_W-1:0]  ld_value
);
   logic [BYTE_W-1:0] staged_lo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         staged_lo <= '0;
         ld_count  <= 1'b0;
         ld_delta  <= 1'b0;
         ld_value  <= '0;
      end else begin
         if (lo_we) staged_lo <= wdata;
         ld_count <= hi_we && !running;
         ld_delta <= hi_we && running;
         if (hi_we) ld_value <= {wdata, staged_lo};
      end
   end

   p_load_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld_count && ld_delta));
   p_delta_running_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ld_delta |-> $past(running));
   p_count_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ld_count |-> !$past(running));
   p_load_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_count || ld_delta) |-> $past(hi_we));
endmodule

// File: rtl/tsr_read_latch.sv
module tsr_read_latch
   import tsr_pkg::*;
#(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned TMR_W  = 16,
   parameter int unsigned OVF_W  = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  adr_t              rd_addr,
   input  logic              tsel_ok,
   input  logic              osel_ok,
   input  logic              lmode,
   input  logic [BYTE_W-1:0] ctrl_byte,
   input  logic [TMR_W-1:0]  tmr_value,
   input  logic [OVF_W-1:0]  ovf_count,
   output logic [BYTE_W-1:0] rdata
);
   localparam int unsigned OVF_BYTES = OVF_W / BYTE_W;

   logic [BYTE_W-1:0] hi_q;
   logic [OVF_W-1:0]  ovf_q;
   logic              lo_rd, ob0_rd;
   logic [BYTE_W-1:0] rd_next;

   assign lo_rd  = rd_en && (rd_addr == ADR_TLO) && tsel_ok;
   assign ob0_rd = rd_en && (rd_addr == ADR_OB0) && osel_ok && !lmode;

   always_comb begin
      rd_next = '0;
      if (rd_addr == ADR_CTRL) rd_next = ctrl_byte;
      if (rd_addr == ADR_TLO && tsel_ok) rd_next = tmr_value[BYTE_W-1:0];
      if (rd_addr == ADR_THI && tsel_ok) rd_next = hi_q;
      for (int k = 0; k < OVF_BYTES; k++) begin
         if (osel_ok && rd_addr == adr_t'(int'(ADR_OB0) + k)) begin
            if (k == 0 && !lmode) rd_next = ovf_count[BYTE_W-1:0];
            else                  rd_next = ovf_q[k*BYTE_W +: BYTE_W];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q  <= '0;
         ovf_q <= '0;
         rdata <= '0;
      end else begin
         if (rd_en) rdata <= rd_next;
         if (lo_rd) begin
            hi_q <= tmr_value[TMR_W-1:BYTE_W];
            if (lmode) ovf_q <= ovf_count;
         end
         if (ob0_rd) ovf_q[OVF_W-1:BYTE_W] <= ovf_count[OVF_W-1:BYTE_W];
      end
   end

   p_hi_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
      lo_rd |=> hi_q == $past(tmr_value[TMR_W-1:BYTE_W]));
   p_full_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_rd && lmode) |=> ovf_q == $past(ovf_count));
   p_upper_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ob0_rd |=> ovf_q[OVF_W-1:BYTE_W] == $past(ovf_count[OVF_W-1:BYTE_W]));
   p_rdata_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));
   p_sel_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == ADR_TLO && !tsel_ok) |=> rdata == '0);
endmodule

// File: rtl/tstamp_regif.sv
module tstamp_regif
   import tsr_pkg::*;
#(
   parameter int unsigned BYTE_W   = 8,
   parameter int unsigned TMR_W    = 16,
   parameter int unsigned OVF_W    = 24,
   parameter int unsigned SEL_W    = 3,
   parameter bit          LATCH_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADR_W-1:0]  bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   input  logic [TMR_W-1:0]  tmr_value,
   input  logic              tmr_ovf,
   input  logic              tmr_running,
   output logic              ld_count,
   output logic              ld_delta,
   output logic [TMR_W-1:0]  ld_value
);
   localparam int unsigned CTRL_BITS = 1 + 2 * SEL_W;
   localparam int unsigned TSEL_LO   = 1;
   localparam int unsigned OSEL_LO   = 1 + SEL_W;
   localparam logic [BYTE_W-1:0] CTRL_MASK = BYTE_W'((1 << CTRL_BITS) - 1);

   initial begin
      assert (TMR_W == 2 * BYTE_W) else $error("timer must span two bytes");
      assert (OVF_W % BYTE_W == 0) else $error("overflow width must be whole bytes");
      assert (OVF_W / BYTE_W + int'(ADR_OB0) <= (1 << ADR_W))
         else $error("overflow bytes exceed address space");
      assert (CTRL_BITS <= BYTE_W) else $error("control fields exceed one byte");
   end

   logic [BYTE_W-1:0] ctrl_q;
   logic [OVF_W-1:0]  ovf_count;
   logic              tsel_ok, osel_ok, lmode;
   logic              lo_we, hi_we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q <= '0;
      else if (bus_wr && bus_addr == ADR_CTRL) ctrl_q <= bus_wdata & CTRL_MASK;
   end

   assign tsel_ok = (ctrl_q[TSEL_LO +: SEL_W] == '0);
   assign osel_ok = (ctrl_q[OSEL_LO +: SEL_W] == '0);

   generate
      if (LATCH_EN) begin : g_latch_mode
         assign lmode = ctrl_q[0];
      end else begin : g_no_latch_mode
         assign lmode = 1'b0;
      end
   endgenerate

   assign lo_we = bus_wr && (bus_addr == ADR_TLO) && tsel_ok;
   assign hi_we = bus_wr && (bus_addr == ADR_THI) && tsel_ok;

   tsr_ovf_counter #(.OVF_W(OVF_W)) i_ovf (
      .clk(clk), .rst_n(rst_n), .inc(tmr_ovf), .count(ovf_count));

   tsr_write_stage #(.BYTE_W(BYTE_W), .TMR_W(TMR_W)) i_wstage (
      .clk(clk), .rst_n(rst_n), .lo_we(lo_we), .hi_we(hi_we),
      .wdata(bus_wdata), .running(tmr_running),
      .ld_count(ld_count), .ld_delta(ld_delta), .ld_value(ld_value));

   tsr_read_latch #(.BYTE_W(BYTE_W), .TMR_W(TMR_W), .OVF_W(OVF_W)) i_rlatch (
      .clk(clk), .rst_n(rst_n), .rd_en(bus_rd), .rd_addr(bus_addr),
      .tsel_ok(tsel_ok), .osel_ok(osel_ok), .lmode(lmode),
      .ctrl_byte(ctrl_q), .tmr_value(tmr_value), .ovf_count(ovf_count),
      .rdata(bus_rdata));

   p_ctrl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADR_CTRL) |=> ctrl_q == ($past(bus_wdata) & CTRL_MASK));
endmodule

// File: tb/test_tstamp_regif.sv
module test_tstamp_regif;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [15:0] tmr_value = '0;
   logic        tmr_ovf = 1'b0, tmr_running = 1'b0;
   logic        ld_count, ld_delta;
   logic [15:0] ld_value;

   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;
   int unsigned exp_ovf = 0;
   logic        w_cnt, w_dlt;
   logic [15:0] w_val;

   always #4 clk = ~clk;

   tstamp_regif i_tstamp_regif (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_value(tmr_value),
      .tmr_ovf(tmr_ovf), .tmr_running(tmr_running),
      .ld_count(ld_count), .ld_delta(ld_delta), .ld_value(ld_value));

   task automatic check(input string req, input int unsigned act, input int unsigned exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk); bus_wr = 1'b0;
      w_cnt = ld_count; w_dlt = ld_delta; w_val = ld_value;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk); bus_addr = a; bus_rd = 1'b1;
      @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
   endtask

   task automatic pulses(input int n);
      @(negedge clk); tmr_ovf = 1'b1;
      repeat (n) @(negedge clk);
      tmr_ovf = 1'b0;
      exp_ovf += n;
   endtask

   task automatic t_reset;
      logic [7:0] d;
      check("R1 rdata", bus_rdata, 0);
      check("R1 ld_count", ld_count, 0);
      check("R1 ld_delta", ld_delta, 0);
      rd(3'd0, d); check("R1 ctrl", d, 0);
      rd(3'd3, d); check("R1 ovf byte0", d, 0);
      @(negedge clk); check("R1 rdata held", bus_rdata, 0);
   endtask

   task automatic t_count;
      logic [7:0] d;
      pulses(305);
      rd(3'd3, d); check("R2 ovf byte0", d, exp_ovf & 8'hFF);
      rd(3'd4, d); check("R2 ovf byte1", d, (exp_ovf >> 8) & 8'hFF);
      rd(3'd5, d); check("R2 ovf byte2", d, (exp_ovf >> 16) & 8'hFF);
   endtask

   task automatic t_upper_latch;
      logic [7:0] d;
      int unsigned snap;
      snap = exp_ovf;
      rd(3'd3, d); check("R5 live byte0", d, snap & 8'hFF);
      pulses(260);
      rd(3'd4, d); check("R5 latched byte1", d, (snap >> 8) & 8'hFF);
      rd(3'd5, d); check("R5 latched byte2", d, (snap >> 16) & 8'hFF);
   endtask

   task automatic t_timer_latch;
      logic [7:0] d;
      tmr_value = 16'hBEEF;
      rd(3'd1, d); check("R3 timer low", d, 8'hEF);
      tmr_value = 16'h1234;
      rd(3'd2, d); check("R3 timer high latched", d, 8'hBE);
   endtask

   task automatic t_stamp;
      logic [7:0] d;
      int unsigned snap;
      wr(3'd0, 8'h01);
      tmr_value = 16'hA55A;
      snap = exp_ovf;
      rd(3'd1, d); check("R4 timer low", d, 8'h5A);
      tmr_value = 16'h0F0F;
      pulses(300);
      rd(3'd2, d); check("R4 timer high", d, 8'hA5);
      rd(3'd3, d); check("R4 stamp byte0", d, snap & 8'hFF);
      rd(3'd4, d); check("R4 stamp byte1", d, (snap >> 8) & 8'hFF);
      rd(3'd5, d); check("R4 stamp byte2", d, (snap >> 16) & 8'hFF);
      wr(3'd0, 8'h00);
   endtask

   task automatic t_writes;
      tmr_running = 1'b0;
      wr(3'd1, 8'h34);
      check("R6 no pulse on low", {w_cnt, w_dlt}, 0);
      wr(3'd2, 8'h12);
      check("R7 count pulse", w_cnt, 1);
      check("R7 no delta", w_dlt, 0);
      check("R7 value", w_val, 16'h1234);
      @(negedge clk); check("R7 pulse one cycle", ld_count, 0);
      tmr_running = 1'b1;
      wr(3'd1, 8'h78);
      wr(3'd2, 8'h56);
      check("R8 delta pulse", w_dlt, 1);
      check("R8 no count", w_cnt, 0);
      check("R8 value", w_val, 16'h5678);
      wr(3'd2, 8'h9A);
      check("R9 reuse staged low", w_val, 16'h9A78);
      tmr_running = 1'b0;
   endtask

   task automatic t_select;
      logic [7:0] d;
      tmr_value = 16'h4321;
      wr(3'd0, 8'h02);
      rd(3'd1, d); check("R10 timer low masked", d, 0);
      wr(3'd1, 8'hFF);
      check("R10 low write ignored", {w_cnt, w_dlt}, 0);
      wr(3'd2, 8'hEE);
      check("R10 high write ignored", {w_cnt, w_dlt}, 0);
      wr(3'd0, 8'h10);
      rd(3'd3, d); check("R10 ovf byte masked", d, 0);
      wr(3'd0, 8'h00);
      wr(3'd2, 8'h11);
      check("R10 staged byte kept", w_val, 16'h1178);
   endtask

   task automatic t_ctrl;
      logic [7:0] d;
      wr(3'd0, 8'hFF);
      rd(3'd0, d); check("R11 ctrl readback", d, 8'h7F);
      wr(3'd0, 8'h00);
      rd(3'd6, d); check("R11 unmapped 6", d, 0);
      rd(3'd7, d); check("R11 unmapped 7", d, 0);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_count();
      t_upper_latch();
      t_timer_latch();
      t_stamp();
      t_writes();
      t_select();
      t_ctrl();
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule